// File: doc/BRIEF.md
# General-Purpose Output Port Register Bank

This block is one 32-bit general-purpose output port behind a small synchronous register bus. Software either writes the whole output data register directly or uses three write-only alias registers. One alias forces chosen bits high, one forces them low and one inverts them. Bits written as zero in an alias are left untouched, so one task can change its own pins without a read-modify-write that could undo another task's update.

The port decodes a 64-byte window, so several instances can sit at consecutive 0x40 strides. A parameter gives the mask of implemented pins. Unimplemented bits are never stored, read back as zero and never drive. A per-pin configuration input marks which pins currently act as general-purpose outputs. Only those pins present their stored level and assert their output enable. All other pins drive low with the enable off, and their stored bits are kept.

Top module: `gpo_port`

## Requirements
- R1: After a synchronous active-high reset the data register is all zeros, `pin_out` and `bus_rdata` are zero.
- R2: A write to offset 0x00 loads `bus_wdata` into the data register in one clock, restricted to implemented bits. A read of offset 0x00 returns the stored value.
- R3: A write to offset 0x04 (set alias) forces every data bit written as 1 to 1 and leaves bits written as 0 unchanged.
- R4: A write to offset 0x08 (clear alias) forces every data bit written as 1 to 0 and leaves bits written as 0 unchanged.
- R5: A write to offset 0x0C (toggle alias) inverts every data bit written as 1 and leaves bits written as 0 unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C always return zero.
- R7: Bits outside `IMPL_MASK` (default 0x3FFF_FFFF, so bits 31:30 are absent) read as zero, stay zero under every write, and never drive `pin_out` or `pin_oe`.
- R8: For an implemented pin n, `pin_oe[n]` equals `out_cfg[n]`. `pin_out[n]` equals the data bit when `out_cfg[n]` is 1 and is 0 otherwise. Changing `out_cfg` never alters the stored data bit.
- R9: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C (including unaligned ones) return zero, and writes to them change nothing.
- R10: Read data is registered. It appears on `bus_rdata` in the cycle after `bus_rd` is sampled and is zero in cycles following no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset within the port's 64-byte window |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| out_cfg | input | 32 | Per-pin flag: pin configured as general-purpose output |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |

## Verification
The register operations run as one chain in which each step starts from the state the previous step left. In that chain, set, clear and toggle alias writes get patterns whose ones fall on both stored ones and stored zeros, which tells a true masked update apart from a plain load or an OR. Some steps carry all-zero alias data or hit unmapped, top-of-window and unaligned offsets, where the register must stay unchanged. Patterns with ones in the absent top bits show whether those bits are ever stored. Directed steps then switch `out_cfg` between full, partial and empty masks to separate the pin gating from the stored data. They also check read latency and that alias reads return zero.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int unsigned PORT_W = 32;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_DATA = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_SET  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_TGL  = 6'h0C;

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_TGL
    } wr_op_e;

    typedef struct packed {
        wr_op_e op;
        logic   rd_data;
        logic   rd_alias;
    } dec_t;

    function automatic port_vec_t apply_op(wr_op_e op, port_vec_t cur,
                                           port_vec_t wd, port_vec_t impl);
        port_vec_t nxt;
        case (op)
            OP_LOAD: nxt = wd;
            OP_SET:  nxt = cur | wd;
            OP_CLR:  nxt = cur & ~wd;
            OP_TGL:  nxt = cur ^ wd;
            default: nxt = cur;
        endcase
        return nxt & impl;
    endfunction

endpackage

// File: rtl/gpo_addr_dec.sv
module gpo_addr_dec
    import gpo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output dec_t              dec
);
    always_comb begin
        dec = '{op: OP_IDLE, rd_data: 1'b0, rd_alias: 1'b0};
        if (wr) begin
            case (addr)
                OFF_DATA: dec.op = OP_LOAD;
                OFF_SET:  dec.op = OP_SET;
                OFF_CLR:  dec.op = OP_CLR;
                OFF_TGL:  dec.op = OP_TGL;
                default:  dec.op = OP_IDLE;
            endcase
        end
        if (rd) begin
            dec.rd_data  = (addr == OFF_DATA);
            dec.rd_alias = (addr == OFF_SET) || (addr == OFF_CLR) ||
                           (addr == OFF_TGL);
        end
    end
endmodule

// File: rtl/gpo_data_reg.sv
module gpo_data_reg
    import gpo_pkg::*;
#(
    parameter port_vec_t IMPL_MASK = 32'h3FFF_FFFF
) (
    input  logic      clk,
    input  logic      rst,
    input  wr_op_e    op,
    input  port_vec_t wdata,
    output port_vec_t data_q
);
    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= apply_op(op, data_q, wdata, IMPL_MASK);
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (data_q == '0));

    p_set_no_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET) |=> ((data_q & $past(data_q)) == $past(data_q)));

    p_clr_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |=> ((data_q & ~$past(data_q)) == '0));

    p_tgl_zero_noop_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TGL && wdata == '0) |=> $stable(data_q));

    p_absent_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (data_q & ~IMPL_MASK) == '0);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(data_q));
endmodule

// File: rtl/gpo_pin_stage.sv
module gpo_pin_stage
    import gpo_pkg::*;
#(
    parameter port_vec_t IMPL_MASK = 32'h3FFF_FFFF
) (
    input  logic      clk,
    input  logic      rst,
    input  port_vec_t data,
    input  port_vec_t cfg,
    output port_vec_t pin_out,
    output port_vec_t pin_oe
);
    for (genvar n = 0; n < PORT_W; n++) begin : g_pin
        if (IMPL_MASK[n]) begin : g_impl
            assign pin_oe[n]  = cfg[n];
            assign pin_out[n] = cfg[n] & data[n];
        end else begin : g_absent
            assign pin_oe[n]  = 1'b0;
            assign pin_out[n] = 1'b0;
        end
    end

    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));

    p_absent_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (((pin_out | pin_oe) & ~IMPL_MASK) == '0));
endmodule

// File: rtl/gpo_port.sv
module gpo_port
    import gpo_pkg::*;
#(
    parameter port_vec_t IMPL_MASK = 32'h3FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] out_cfg,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    dec_t      dec;
    port_vec_t data_q;
    port_vec_t rdata_q;

    gpo_addr_dec i_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dec  (dec)
    );

    gpo_data_reg #(.IMPL_MASK(IMPL_MASK)) i_reg (
        .clk    (clk),
        .rst    (rst),
        .op     (dec.op),
        .wdata  (bus_wdata),
        .data_q (data_q)
    );

    gpo_pin_stage #(.IMPL_MASK(IMPL_MASK)) i_pins (
        .clk     (clk),
        .rst     (rst),
        .data    (data_q),
        .cfg     (out_cfg),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // Read returns the pre-write value when a read and write share a cycle.
    always_ff @(posedge clk) begin
        if (rst)              rdata_q <= '0;
        else if (dec.rd_data) rdata_q <= data_q;
        else                  rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    p_alias_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        dec.rd_alias |=> (bus_rdata == '0));

    p_no_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/test_gpo_port.sv
module test_gpo_port;
    import gpo_pkg::*;

    localparam port_vec_t IMPL = 32'h3FFF_FFFF;
    localparam int NV = 10;

    // {offset, write data, expected data register afterwards}
    localparam logic [ADDR_W+2*PORT_W-1:0] VEC [NV] = '{
        {6'h00, 32'hA5A5_A5A5, 32'h25A5_A5A5},  // R2 load, R7 top bits dropped
        {6'h04, 32'hC000_000F, 32'h25A5_A5AF},  // R3 set
        {6'h08, 32'h0000_00FF, 32'h25A5_A500},  // R4 clear
        {6'h0C, 32'hFFFF_0000, 32'h1A5A_A500},  // R5 toggle
        {6'h04, 32'h0000_0000, 32'h1A5A_A500},  // R3 zero set
        {6'h10, 32'hFFFF_FFFF, 32'h1A5A_A500},  // R9 unmapped
        {6'h08, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 clear all
        {6'h0C, 32'h0000_0001, 32'h0000_0001},  // R5 toggle one
        {6'h3C, 32'hFFFF_FFFF, 32'h0000_0001},  // R9 top of window
        {6'h02, 32'h1234_5678, 32'h0000_0001}   // R9 unaligned
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [PORT_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [PORT_W-1:0] bus_rdata;
    logic [PORT_W-1:0] out_cfg = '1;
    logic [PORT_W-1:0] pin_out;
    logic [PORT_W-1:0] pin_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    gpo_port #(.IMPL_MASK(IMPL)) i_gpo_port (
        .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
        .out_cfg, .pin_out, .pin_oe
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        check("R1 data", pin_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst = 1'b0;
        bus_read(OFF_DATA, rv);
        check("R1 read", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] wd, ex;
            {a, wd, ex} = VEC[i];
            bus_write(a, wd);
            check("R2/R3/R4/R5/R9 pins", pin_out, ex);
            bus_read(OFF_DATA, rv);
            check("R2/R3/R4/R5/R7/R9 read", rv, ex);
        end

        // R6 alias reads
        bus_write(OFF_DATA, 32'hFFFF_FFFF);
        bus_read(OFF_SET, rv); check("R6 set read", rv, 32'h0);
        bus_read(OFF_CLR, rv); check("R6 clr read", rv, 32'h0);
        bus_read(OFF_TGL, rv); check("R6 tgl read", rv, 32'h0);
        bus_read(6'h20, rv);   check("R9 unmapped read", rv, 32'h0);

        // R7 absent pins never drive
        check("R7 pin_out", pin_out, IMPL);
        check("R7 pin_oe", pin_oe, IMPL);

        // R8 pin gating and retention
        @(negedge clk); out_cfg = 32'h0000_FFFF;
        @(negedge clk);
        check("R8 pin_out partial", pin_out, 32'h0000_FFFF);
        check("R8 pin_oe partial", pin_oe, 32'h0000_FFFF);
        out_cfg = '0;
        @(negedge clk);
        check("R8 pin_out off", pin_out, 32'h0);
        check("R8 pin_oe off", pin_oe, 32'h0);
        bus_read(OFF_DATA, rv);
        check("R8 retained", rv, IMPL);
        out_cfg = '1;
        @(negedge clk);
        check("R8 restored", pin_out, IMPL);

        // R10 read latency: data in the cycle after, zero afterwards
        @(negedge clk);
        bus_addr = OFF_DATA; bus_rd = 1'b1;
        check("R10 before edge", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R10 after edge", bus_rdata, IMPL);
        @(negedge clk);
        check("R10 no read", bus_rdata, 32'h0);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset", pin_out, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule